// File: doc/BRIEF.md
# Burst Read-Modify-Write Bus Master

This block is a bus master that works on one block of consecutive words in memory. It reads a block of `BLK_LEN` words that starts at a fixed byte address, one word request per clock cycle. It then spends one cycle per word adding each word's index within the block to that word. Finally it writes the block back to the same addresses, again one word per cycle, and stays quiet for a fixed number of idle cycles before it starts the next round.

Because each word is a separate bus request, an arbiter can grant a more urgent master between two words of a burst. From this master's side, such a stall looks like a WAIT status. The priority value and the lock flag are fixed by parameters. A failed transfer sets a sticky error flag and records the byte address that failed, and the master still finishes the round.

Top module: `burst_rmw_master`

## Requirements
- R1: While `rst` is high, `bus_req` is 0, `err_flag` is 0 and `err_addr` is 0.
- R2: In the first cycle after `rst` falls, `bus_req` is 1, `bus_we` is 0 and `bus_addr` equals `START_ADDR`.
- R3: A read burst completes `BLK_LEN` beats at byte addresses `START_ADDR + 4*k` for k = 0 .. `BLK_LEN`-1, in ascending order, with `bus_we` = 0.
- R4: The word written back for beat k equals the word read at beat k plus k, modulo 2^`DATA_W`.
- R5: After the last read beat completes, `bus_req` stays 0 for exactly `BLK_LEN` cycles, and then the write burst starts.
- R6: A write burst completes `BLK_LEN` beats to the same ascending addresses as the read, with `bus_we` = 1 and `bus_wdata` as given by R4.
- R7: After the last write beat completes, `bus_req` stays 0 for exactly `IDLE_CYCLES` cycles, and then the next read burst starts at `START_ADDR`.
- R8: `bus_status` is decoded as 2'b00 WAIT, 2'b01 OK, 2'b10 ERROR and 2'b11 WAIT. A beat ends only on OK or ERROR. During WAIT the master keeps `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` unchanged.
- R9: `bus_prio` always equals `PRIO`. `bus_lock` equals `LOCK_EN` while `bus_req` is 1 and is 0 otherwise. The defaults are `PRIO` = 4 and `LOCK_EN` = 0.
- R10: A beat that ends with ERROR sets `err_flag` and loads `err_addr` with that beat's address in the next cycle. Only reset clears `err_flag`. `err_addr` holds the address of the most recent failure.
- R11: After an ERROR the round continues with no change in timing. A read beat that fails stores 0 as that word, so the value written back for it is its index k. A write beat that fails leaves that memory word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | output | 1 | Request for the current beat |
| bus_prio | output | PRIO_W | Fixed priority value |
| bus_lock | output | 1 | Lock request, valid with bus_req |
| bus_addr | output | ADDR_W | Byte address of the current beat |
| bus_we | output | 1 | 1 for a write beat, 0 for a read beat |
| bus_wdata | output | DATA_W | Write data of the current beat |
| bus_rdata | input | DATA_W | Read data, sampled when a read beat ends |
| bus_status | input | 2 | Beat status: 00 WAIT, 01 OK, 10 ERROR, 11 WAIT |
| err_flag | output | 1 | Sticky error flag |
| err_addr | output | ADDR_W | Address of the most recent failed beat |

## Verification
Every result of this block has a fixed latency from the cycle in which the bus answers. The first request appears one cycle after reset is released. The beat address moves to the next word in the cycle after an OK or ERROR, and stays put after a WAIT. The request stays low for exactly 16 cycles between the bursts and for exactly 15 idle cycles after a write burst. The error flag and the failed address appear one cycle after the ERROR. The bench answers and samples on the falling clock edge. It measures each low-request gap in whole cycles, and it compares memory only at the idle point after each round, so every sample falls where the value has already settled.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_COMP  = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;

    localparam logic [1:0] BST_WAIT = 2'b00;
    localparam logic [1:0] BST_OK   = 2'b01;
    localparam logic [1:0] BST_ERR  = 2'b10;

    typedef struct packed {
        logic cap;
        logic add;
    } buf_cmd_t;

    function automatic logic st_done(input logic [1:0] st);
        return (st == BST_OK) || (st == BST_ERR);
    endfunction

    function automatic logic st_fail(input logic [1:0] st);
        return st == BST_ERR;
    endfunction

endpackage

// File: rtl/rmw_seq.sv
module rmw_seq
    import rmw_pkg::*;
#(
    parameter int BLK_LEN     = 16,
    parameter int IDLE_CYCLES = 15,
    parameter int ADDR_W      = 8,
    parameter int START_ADDR  = 'h4C,
    localparam int IDX_W      = $clog2(BLK_LEN),
    localparam int TMR_W      = $clog2(IDLE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        status,
    output logic [IDX_W-1:0]  idx,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic              beat_end,
    output buf_cmd_t          cmd
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BLK_LEN - 1);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(IDLE_CYCLES - 1);

    phase_e            phase_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TMR_W-1:0]  tmr_q;

    always_comb begin
        req      = (phase_q == PH_READ) || (phase_q == PH_WRITE);
        we       = (phase_q == PH_WRITE);
        addr     = ADDR_W'(START_ADDR) + ADDR_W'({idx_q, 2'b00});
        beat_end = req && st_done(status);
        cmd.cap  = (phase_q == PH_READ) && beat_end;
        cmd.add  = (phase_q == PH_COMP);
        idx      = idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            tmr_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (tmr_q == '0) begin
                        phase_q <= PH_READ;
                        idx_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                PH_READ: begin
                    if (beat_end) begin
                        if (idx_q == LAST) begin
                            phase_q <= PH_COMP;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                PH_COMP: begin
                    if (idx_q == LAST) begin
                        phase_q <= PH_WRITE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                PH_WRITE: begin
                    if (beat_end) begin
                        if (idx_q == LAST) begin
                            phase_q <= PH_IDLE;
                            idx_q   <= '0;
                            tmr_q   <= TMR_LOAD;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R8: a stalled beat keeps its request, direction and address
    assert_wait_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (req && !st_done(status)) |=> (req && $stable(addr) && $stable(we)));

    // R3: each finished read beat moves the address one word forward
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (req && !we && st_done(status) && idx_q != LAST)
            |=> (addr == $past(addr) + ADDR_W'(4)));

    // R5: the last read beat is followed by a cycle with no request
    assert_comp_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (req && !we && st_done(status) && idx_q == LAST) |=> !req);

endmodule

// File: rtl/rmw_buf.sv
module rmw_buf
    import rmw_pkg::*;
#(
    parameter int BLK_LEN = 16,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(BLK_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  buf_cmd_t          cmd,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              cap_fail,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] words [BLK_LEN];

    for (genvar g = 0; g < BLK_LEN; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (idx == IDX_W'(g)) begin
                if (cmd.cap) begin
                    words[g] <= cap_fail ? '0 : cap_data;
                end else if (cmd.add) begin
                    words[g] <= words[g] + DATA_W'(g);
                end
            end
        end
    end

    assign rd_word = words[idx];

    // R4: capture and modify never collide in one cycle
    assert_cmd_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(cmd.cap && cmd.add));

    // R4: a modify step adds exactly the word's index
    assert_add_index_R4: assert property (@(posedge clk) disable iff (rst)
        cmd.add |=> (words[$past(idx)] == $past(rd_word) + DATA_W'($past(idx))));

endmodule

// File: rtl/rmw_err.sv
module rmw_err
    import rmw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_end,
    input  logic [1:0]        status,
    input  logic [ADDR_W-1:0] addr,
    output logic              err_flag,
    output logic [ADDR_W-1:0] err_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag <= 1'b0;
            err_addr <= '0;
        end else if (beat_end && st_fail(status)) begin
            err_flag <= 1'b1;
            err_addr <= addr;
        end
    end

    // R10: a failed beat is recorded one cycle later
    assert_err_record_R10: assert property (@(posedge clk) disable iff (rst)
        (beat_end && st_fail(status)) |=> (err_flag && err_addr == $past(addr)));

    // R10: the flag never falls outside reset
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

endmodule

// File: rtl/burst_rmw_master.sv
module burst_rmw_master
    import rmw_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int BLK_LEN     = 16,
    parameter int START_ADDR  = 'h4C,
    parameter int IDLE_CYCLES = 15,
    parameter int PRIO_W      = 3,
    parameter int PRIO        = 4,
    parameter bit LOCK_EN     = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              bus_req,
    output logic [PRIO_W-1:0] bus_prio,
    output logic              bus_lock,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        bus_status,
    output logic              err_flag,
    output logic [ADDR_W-1:0] err_addr
);
    localparam int IDX_W = $clog2(BLK_LEN);

    logic [IDX_W-1:0]  idx;
    logic              beat_end;
    buf_cmd_t          cmd;
    logic [DATA_W-1:0] rd_word;

    rmw_seq #(
        .BLK_LEN    (BLK_LEN),
        .IDLE_CYCLES(IDLE_CYCLES),
        .ADDR_W     (ADDR_W),
        .START_ADDR (START_ADDR)
    ) i_seq (
        .clk     (clk),
        .rst     (rst),
        .status  (bus_status),
        .idx     (idx),
        .req     (bus_req),
        .we      (bus_we),
        .addr    (bus_addr),
        .beat_end(beat_end),
        .cmd     (cmd)
    );

    rmw_buf #(
        .BLK_LEN(BLK_LEN),
        .DATA_W (DATA_W)
    ) i_buf (
        .clk     (clk),
        .rst     (rst),
        .idx     (idx),
        .cmd     (cmd),
        .cap_data(bus_rdata),
        .cap_fail(st_fail(bus_status)),
        .rd_word (rd_word)
    );

    rmw_err #(
        .ADDR_W(ADDR_W)
    ) i_err (
        .clk     (clk),
        .rst     (rst),
        .beat_end(beat_end),
        .status  (bus_status),
        .addr    (bus_addr),
        .err_flag(err_flag),
        .err_addr(err_addr)
    );

    assign bus_prio  = PRIO_W'(PRIO);
    assign bus_lock  = LOCK_EN && bus_req;
    assign bus_wdata = bus_we ? rd_word : '0;

    // R9: no lock without a request
    assert_lock_gate_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_req |-> !bus_lock);

    // R8: write data stays put while a write beat is stalled
    assert_wdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && !st_done(bus_status)) |=> $stable(bus_wdata));

endmodule

// File: tb/test_burst_rmw_master.sv
module test_burst_rmw_master;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int BLK    = 16;
    localparam int START  = 'h4C;
    localparam int IDLE   = 15;
    localparam int BASEW  = START / 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_req, bus_lock, bus_we, err_flag;
    logic [2:0]        bus_prio;
    logic [ADDR_W-1:0] bus_addr, err_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic [1:0]        bus_status = 2'b00;

    always #10 clk = ~clk;

    burst_rmw_master i_burst_rmw_master (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_prio(bus_prio),
        .bus_lock(bus_lock), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_status(bus_status),
        .err_flag(err_flag), .err_addr(err_addr)
    );

    int total = 0;
    int bad   = 0;
    logic [DATA_W-1:0] mem [64];
    logic [DATA_W-1:0] exp_w [BLK];
    logic [DATA_W-1:0] snap [BLK];
    int ws = 0, wcnt = 0, err_rd = -1, err_wr = -1;
    int rd_k = 0, wr_k = 0, wr_done = 0, gap = 0;
    int last_wr_gap = -1, last_idle_gap = -1;
    logic prev_req = 0, prev_wait = 0, prev_we = 0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [DATA_W-1:0] prev_wdata = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // memory responder and beat monitor, all on the falling edge
    always @(negedge clk) begin
        bit fail;
        bus_status = 2'b00;
        bus_rdata  = '0;
        if (!rst && bus_req) begin
            if (prev_wait) begin
                chk(bus_addr == prev_addr && bus_we == prev_we && bus_wdata == prev_wdata,
                    "R8", "stalled beat changed", bus_addr, prev_addr);
            end
            if (!prev_req) begin
                if (bus_we) last_wr_gap = gap; else last_idle_gap = gap;
            end
            gap = 0;
            if (wcnt < ws) begin
                wcnt++;
                bus_status = 2'b00;
            end else begin
                wcnt = 0;
                fail = bus_we ? (int'(bus_addr) == err_wr) : (int'(bus_addr) == err_rd);
                bus_status = fail ? 2'b10 : 2'b01;
                chk(bus_prio == 3'd4 && bus_lock == 1'b0, "R9", "prio/lock",
                    {bus_prio, bus_lock}, 8);
                if (!bus_we) begin
                    chk(int'(bus_addr) == START + 4 * rd_k, "R3", "read addr", bus_addr,
                        START + 4 * rd_k);
                    bus_rdata = mem[bus_addr >> 2];
                    exp_w[rd_k] = (fail ? '0 : bus_rdata) + DATA_W'(rd_k);
                    rd_k = (rd_k + 1) % BLK;
                end else begin
                    chk(int'(bus_addr) == START + 4 * wr_k, "R6", "write addr", bus_addr,
                        START + 4 * wr_k);
                    chk(bus_wdata == exp_w[wr_k], "R4", "write data", bus_wdata, exp_w[wr_k]);
                    if (!fail) mem[bus_addr >> 2] = bus_wdata;
                    wr_k = (wr_k + 1) % BLK;
                    wr_done++;
                end
            end
            prev_wait  = (bus_status == 2'b00);
            prev_addr  = bus_addr;
            prev_we    = bus_we;
            prev_wdata = bus_wdata;
        end else if (!rst) begin
            gap++;
            prev_wait = 1'b0;
        end
        prev_req = rst ? 1'b0 : bus_req;
    end

    task automatic take_snap();
        for (int i = 0; i < BLK; i++) snap[i] = mem[BASEW + i];
    endtask

    task automatic wait_round_end();
        int target = (wr_done / BLK + 1) * BLK;
        while (wr_done < target) @(negedge clk);
        @(posedge clk);
    endtask

    // mode 0: plain, 1: read of word k failed, 2: write of word k failed
    task automatic check_mem(input string tag, input int mode, input int k);
        for (int i = 0; i < BLK; i++) begin
            logic [DATA_W-1:0] e;
            e = snap[i] + DATA_W'(i);
            if (mode == 1 && i == k) e = DATA_W'(i);
            if (mode == 2 && i == k) e = snap[i];
            chk(mem[BASEW + i] == e, tag, "memory word", mem[BASEW + i], e);
        end
    endtask

    task automatic t_reset_first();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(bus_req == 0 && err_flag == 0 && err_addr == 0, "R1", "reset outputs",
            {bus_req, err_flag, err_addr}, 0);
        take_snap();
        rst = 1'b0;
        @(negedge clk);
        chk(bus_req == 1 && bus_we == 0 && int'(bus_addr) == START, "R2", "first request",
            bus_addr, START);
        wait_round_end();
        check_mem("R4", 0, 0);
        chk(last_wr_gap == BLK, "R5", "compute gap", last_wr_gap, BLK);
    endtask

    task automatic t_wait_states();
        ws = 2;
        take_snap();
        wait_round_end();
        ws = 0;
        check_mem("R8", 0, 0);
        chk(last_idle_gap == IDLE, "R7", "idle gap", last_idle_gap, IDLE);
        chk(last_wr_gap == BLK, "R5", "gap with waits", last_wr_gap, BLK);
    endtask

    task automatic t_read_error();
        err_rd = START + 8;
        take_snap();
        wait_round_end();
        err_rd = -1;
        chk(err_flag == 1 && int'(err_addr) == START + 8, "R10", "read failure record",
            err_addr, START + 8);
        check_mem("R11", 1, 2);
        chk(last_idle_gap == IDLE && last_wr_gap == BLK, "R11", "timing after failure",
            last_wr_gap, BLK);
    endtask

    task automatic t_write_error();
        err_wr = START + 4 * (BLK - 1);
        take_snap();
        wait_round_end();
        err_wr = -1;
        chk(int'(err_addr) == START + 4 * (BLK - 1), "R10", "write failure record",
            err_addr, START + 4 * (BLK - 1));
        check_mem("R11", 2, BLK - 1);
    endtask

    task automatic t_sticky();
        take_snap();
        wait_round_end();
        chk(err_flag == 1 && int'(err_addr) == START + 4 * (BLK - 1), "R10", "sticky record",
            err_addr, START + 4 * (BLK - 1));
        check_mem("R6", 0, 0);
        chk(last_idle_gap == IDLE, "R7", "idle gap again", last_idle_gap, IDLE);
    endtask

    initial begin
        for (int j = 0; j < 64; j++) mem[j] = 32'h1000_0000 + DATA_W'(j) * 32'h0101;
        mem[BASEW + 3] = 32'hFFFF_FFFE;
        t_reset_first();
        t_wait_states();
        t_read_error();
        t_write_error();
        t_sticky();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule